// File: doc/BRIEF.md
# Audio InfoFrame Packet Builder

This block assembles the audio InfoFrame that a display link sends beside the video, and hands it out one byte at a time. A single-cycle start pulse captures seven configuration fields: coding type, channel count, sample-frequency code, sample-size code, channel allocation, downmix-inhibit flag and level-shift value. The block then streams fourteen bytes in a fixed order: three constant header bytes, one checksum byte, and ten payload bytes.

The checksum comes before the payload it covers. For that reason it is formed by a combinational adder tree over the captured fields, so the stream has no warm-up pass and the first byte is offered on the cycle after the start pulse. The output is a valid/ready stream. A byte counts as taken on any rising edge where `out_valid_o` and `out_ready_i` are both high. While `out_ready_i` is low, the data, the last flag and valid hold unchanged. Valid does not drop inside a packet, so a high `out_valid_o` also means a packet is outstanding. A start pulse is accepted only while valid is low.

Top module: `aif_pkt_builder`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_valid_o` and `out_last_o` are low.
- R2: Stream bytes 0, 1 and 2 are 0x84, 0x01 and 0x0A. Byte 0 is offered with valid high on the cycle after an accepted start.
- R3: Stream byte 3 is the checksum. The 8-bit sum of all fourteen streamed bytes is zero.
- R4: Stream byte 4 (payload byte 1) is {coding[3:0], 1'b0, (chan_cnt-1)[2:0]}.
- R5: Stream byte 5 (payload byte 2) is {3'b000, sfreq[2:0], ssize[1:0]}.
- R6: Stream byte 6 (payload byte 3) is 0x00. Stream byte 7 (payload byte 4) is the channel allocation.
- R7: Stream byte 8 (payload byte 5) is {dmix_inh, lshift[3:0], 3'b000}. Stream bytes 9 to 13 are 0x00.
- R8: `out_last_o` is high only with valid, and only on stream byte 13.
- R9: While valid is high and ready is low, on the next cycle valid is still high and data and last are unchanged.
- R10: A start pulse while valid is high is ignored. The stream continues unchanged, and inputs that change after capture have no effect on it.
- R11: Valid falls on the cycle after byte 13 is taken. A later start is accepted and produces a full new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture the fields and launch one packet (only while idle) |
| coding_i | input | 4 | Audio coding type |
| chan_cnt_i | input | 4 | Channel count (1 to 8) |
| sfreq_i | input | 3 | Sample-frequency code |
| ssize_i | input | 2 | Sample-size code |
| challoc_i | input | 8 | Speaker/channel allocation |
| dmix_inh_i | input | 1 | Downmix-inhibit flag |
| lshift_i | input | 4 | Level-shift value |
| out_valid_o | output | 1 | Byte on `out_data_o` is valid |
| out_data_o | output | 8 | Stream byte |
| out_last_o | output | 1 | Marks the final byte of a packet |
| out_ready_i | input | 1 | Sink accepts the byte this cycle |

## Verification
Two cases are hard to reach from the ports: a start pulse that lands while a packet is outstanding, and one that lands on the very cycle the final byte is taken. Reaching either needs a start pulse timed against the sink's acceptance. The stimulus therefore pulses start, with every field inverted, at chosen byte counts inside the receive loop. It also drops ready in several periodic patterns, so that stalls fall on header, checksum and payload positions. A reset asserted mid-packet confirms that the stream is abandoned cleanly and that a fresh packet follows.

// File: rtl/aif_pkg.sv
package aif_pkg;
  localparam int HDR_LEN     = 3;
  localparam int PAYLOAD_LEN = 10;
  localparam int TOTAL_LEN   = HDR_LEN + 1 + PAYLOAD_LEN;
  localparam int CSUM_SLOT   = HDR_LEN;
  localparam int IDX_W       = $clog2(TOTAL_LEN);

  localparam logic [7:0] PKT_TYPE = 8'h84;
  localparam logic [7:0] PKT_VER  = 8'h01;
  localparam logic [7:0] PKT_LEN  = 8'(PAYLOAD_LEN);

  typedef struct packed {
    logic [3:0] coding;
    logic [3:0] chan_cnt;
    logic [2:0] sfreq;
    logic [1:0] ssize;
    logic [7:0] challoc;
    logic       dmix_inh;
    logic [3:0] lshift;
  } aif_cfg_t;
endpackage

// File: rtl/aif_payload_pack.sv
module aif_payload_pack
  import aif_pkg::*;
(
  input  aif_cfg_t                    cfg,
  output logic [PAYLOAD_LEN-1:0][7:0] payload
);
  logic [3:0] ch_m1;
  assign ch_m1 = cfg.chan_cnt - 4'd1;

  for (genvar i = 0; i < PAYLOAD_LEN; i++) begin : g_pl
    if (i == 0) begin : g_b1
      assign payload[i] = {cfg.coding, 1'b0, ch_m1[2:0]};
    end else if (i == 1) begin : g_b2
      assign payload[i] = {3'b000, cfg.sfreq, cfg.ssize};
    end else if (i == 3) begin : g_b4
      assign payload[i] = cfg.challoc;
    end else if (i == 4) begin : g_b5
      assign payload[i] = {cfg.dmix_inh, cfg.lshift, 3'b000};
    end else begin : g_zero
      assign payload[i] = 8'h00;
    end
  end
endmodule

// File: rtl/aif_csum_tree.sv
module aif_csum_tree #(
  parameter int N = 13
) (
  input  logic [N-1:0][7:0] bytes_i,
  output logic [7:0]        csum_o
);
  localparam int LVLS   = (N > 1) ? $clog2(N) : 1;
  localparam int LEAVES = 1 << LVLS;
  localparam int NODES  = 2 * LEAVES - 1;

  logic [7:0] node [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < N) begin : g_used
      assign node[LEAVES - 1 + k] = bytes_i[k];
    end else begin : g_pad
      assign node[LEAVES - 1 + k] = 8'h00;
    end
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign csum_o = ~node[0] + 8'd1;
endmodule

// File: rtl/aif_stream_seq.sv
module aif_stream_seq
  import aif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             load_o,
  output logic             valid_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_LEN - 1);

  logic             valid_q;
  logic [IDX_W-1:0] idx_q;

  assign load_o  = start_i && !valid_q;
  assign valid_o = valid_q;
  assign idx_o   = idx_q;
  assign last_o  = valid_q && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (load_o) begin
      valid_q <= 1'b1;
      idx_q   <= '0;
    end else if (valid_q && ready_i) begin
      if (idx_q == LAST_IDX) valid_q <= 1'b0;
      else                   idx_q   <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/aif_pkt_builder.sv
module aif_pkt_builder
  import aif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [3:0] coding_i,
  input  logic [3:0] chan_cnt_i,
  input  logic [2:0] sfreq_i,
  input  logic [1:0] ssize_i,
  input  logic [7:0] challoc_i,
  input  logic       dmix_inh_i,
  input  logic [3:0] lshift_i,
  output logic       out_valid_o,
  output logic [7:0] out_data_o,
  output logic       out_last_o,
  input  logic       out_ready_i
);
  localparam int SUM_N = HDR_LEN + PAYLOAD_LEN;

  aif_cfg_t                    cfg_q;
  logic [PAYLOAD_LEN-1:0][7:0] payload;
  logic [HDR_LEN-1:0][7:0]     hdr;
  logic [SUM_N-1:0][7:0]       sum_in;
  logic [7:0]                  csum;
  logic                        load;
  logic [IDX_W-1:0]            idx;

  assign hdr = {PKT_LEN, PKT_VER, PKT_TYPE};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= '{coding: coding_i, chan_cnt: chan_cnt_i,
                              sfreq: sfreq_i, ssize: ssize_i,
                              challoc: challoc_i, dmix_inh: dmix_inh_i,
                              lshift: lshift_i};
  end

  aif_payload_pack u_pack (
    .cfg     (cfg_q),
    .payload (payload)
  );

  assign sum_in = {payload, hdr};

  aif_csum_tree #(.N(SUM_N)) u_csum (
    .bytes_i (sum_in),
    .csum_o  (csum)
  );

  aif_stream_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ready_i (out_ready_i),
    .load_o  (load),
    .valid_o (out_valid_o),
    .last_o  (out_last_o),
    .idx_o   (idx)
  );

  always_comb begin
    if (int'(idx) < HDR_LEN)       out_data_o = hdr[idx[1:0]];
    else if (int'(idx) == CSUM_SLOT) out_data_o = csum;
    else                           out_data_o = payload[IDX_W'(idx - IDX_W'(CSUM_SLOT + 1))];
  end
endmodule

// File: rtl/aif_pkt_chk.sv
module aif_pkt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       out_valid_o,
  input logic [7:0] out_data_o,
  input logic       out_last_o,
  input logic       out_ready_i
);
  logic [7:0] acc;
  logic [4:0] taken;
  logic       xfer;

  assign xfer = out_valid_o && out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      taken <= '0;
    end else if (start_i && !out_valid_o) begin
      acc   <= '0;
      taken <= '0;
    end else if (xfer) begin
      acc   <= acc + out_data_o;
      taken <= taken + 5'd1;
    end
  end

  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !rst_n |=> !out_valid_o && !out_last_o); // R1

  AST_FIRST_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !out_valid_o |=> out_valid_o && out_data_o == 8'h84); // R2

  AST_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && out_last_o |-> 8'(acc + out_data_o) == 8'h00); // R3

  AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |-> out_valid_o && taken == 5'd13); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o)); // R9

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && start_i && !(xfer && out_last_o) |=> out_valid_o); // R10

  AST_LAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && out_last_o |=> !out_valid_o); // R11
endmodule

bind aif_pkt_builder aif_pkt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o),
  .out_ready_i (out_ready_i)
);

// File: tb/tb_aif_pkt_builder.sv
module tb_aif_pkt_builder;
  logic       clk = 1'b0;
  logic       rst_n, start_i, dmix_inh_i, out_ready_i;
  logic [3:0] coding_i, chan_cnt_i, lshift_i;
  logic [2:0] sfreq_i;
  logic [1:0] ssize_i;
  logic [7:0] challoc_i, out_data_o;
  logic       out_valid_o, out_last_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  aif_pkt_builder dut (.*);

  // nibbles: coding, count, sfreq, ssize, alloc(2), dmix, lshift, pb1(2), pb2(2), pb5(2), csum(2)
  localparam logic [63:0] VEC [4] = '{
    64'h0_2_0_0_00_0_0_01_00_00_70,
    64'h1_8_3_1_13_1_5_17_0D_A8_92,
    64'hF_1_7_3_FF_1_F_F0_1F_F8_6B,
    64'h2_6_2_2_0B_0_A_25_0A_50_E7
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int k, input logic [63:0] v);
    case (k)
      0: return 8'h84;
      1: return 8'h01;
      2: return 8'h0A;
      3: return v[7:0];
      4: return v[31:24];
      5: return v[23:16];
      7: return v[47:40];
      8: return v[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input int k);
    if (k < 3) return "R2";
    if (k == 3) return "R3";
    if (k == 4) return "R4";
    if (k == 5) return "R5";
    if (k < 8) return "R6";
    return "R7";
  endfunction

  task automatic drive_fields(input logic [63:0] v);
    coding_i   = v[63:60];
    chan_cnt_i = v[59:56];
    sfreq_i    = v[54:52];
    ssize_i    = v[49:48];
    challoc_i  = v[47:40];
    dmix_inh_i = v[36];
    lshift_i   = v[35:32];
  endtask

  task automatic run_packet(input logic [63:0] v, input int mode, input bit poke);
    int         got = 0;
    int         cyc = 0;
    bit         held = 0;
    bit         rdy;
    logic [7:0] hd;
    logic       hl;
    logic [7:0] sum = 8'h00;
    @(negedge clk);
    drive_fields(v);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(out_valid_o && out_data_o == 8'h84, "R2", "first byte after start",
        int'(out_data_o), 8'h84);
    while (got < 14 && cyc < 200) begin
      if (held)
        chk(out_valid_o && out_data_o == hd && out_last_o == hl, "R9",
            "stalled byte held", int'(out_data_o), int'(hd));
      rdy = (mode == 0) ? 1'b1 : (mode == 1) ? ((cyc % 3) != 0) : ((cyc % 2) == 1);
      out_ready_i = rdy;
      if (poke && (got == 6 || got == 13)) begin
        drive_fields(~v);
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (out_valid_o && rdy) begin
        chk(out_data_o == exp_byte(got, v), req_of(got), $sformatf("byte %0d", got),
            int'(out_data_o), int'(exp_byte(got, v)));
        chk(out_last_o == (got == 13), "R8", $sformatf("last flag byte %0d", got),
            int'(out_last_o), int'(got == 13));
        sum  = sum + out_data_o;
        got++;
        held = 0;
      end else begin
        held = out_valid_o;
        hd   = out_data_o;
        hl   = out_last_o;
      end
      cyc++;
      @(negedge clk);
    end
    start_i     = 1'b0;
    out_ready_i = 1'b0;
    chk(got == 14, "R11", "packet byte count", got, 14);
    chk(sum == 8'h00, "R3", "sum of stream bytes", int'(sum), 0);
    chk(!out_valid_o, poke ? "R10" : "R11", "valid after last byte", int'(out_valid_o), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    out_ready_i = 1'b0;
    drive_fields(64'h0);
    repeat (3) @(negedge clk);
    chk(!out_valid_o && !out_last_o, "R1", "outputs in reset", int'(out_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid_o && !out_last_o, "R1", "outputs after reset", int'(out_valid_o), 0);

    for (int i = 0; i < 4; i++) run_packet(VEC[i], i % 3, (i == 1) || (i == 3));

    // reset in the middle of a packet, then a clean packet
    @(negedge clk);
    drive_fields(VEC[2]);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    out_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!out_valid_o && !out_last_o, "R1", "reset mid-packet", int'(out_valid_o), 0);
    rst_n = 1'b1;
    out_ready_i = 1'b0;
    @(negedge clk);
    chk(!out_valid_o, "R1", "idle after mid-packet reset", int'(out_valid_o), 0);
    run_packet(VEC[1], 2, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule